// File: doc/BRIEF.md
# Memory-Device Boundary-Scan Test Port

This block is a reduced boundary-scan test access port for a synchronous memory device. It serves board-level connectivity testing only. A serial host drives a test clock, a mode-select line and a serial data input. The port returns serial data on one output, which comes with its own pad enable. The standard sixteen-state controller routes the serial path through one of three registers: a 3-bit instruction register, a one-bit bypass stage, or a data path. The data path is either a 32-bit identification code or a boundary register that captures the device pins. Memory contents are never reachable from the serial path.

The port has no separate test reset. An asynchronous power-on reset places the controller in its reset state, and so does holding the mode-select line high for five clocks. Two instruction codes sample the pins while a control output forces the memory data pins to high impedance. One code samples the pins without that override. One code selects the identification register. All remaining codes select bypass. A mode-select or serial input that is not driven low is read as logic 1.

Top module: `memtap`

## Requirements
- R1: On the rising test clock the controller follows the standard sixteen-state transition graph under mode-select. Power-on reset puts it in Test-Logic-Reset, and five clocks with mode-select high reach Test-Logic-Reset from any state.
- R2: In Test-Logic-Reset the active instruction becomes IDCODE (3'b001) and `hiz_force` is low.
- R3: Capture-IR loads 3'b001 into the instruction shift stage, so the first three bits shifted out (LSB first) are 1, 0, 0.
- R4: A newly shifted instruction takes effect only at Update-IR. Until then `hiz_force` and the selected data path keep their previous values.
- R5: Opcode decode (LSB shifted first): 3'b000 and 3'b010 select SAMPLE-Z and 3'b100 selects SAMPLE, all three through the boundary register. 3'b001 selects the identification register. 3'b011, 3'b101, 3'b110 and 3'b111 select bypass.
- R6: `hiz_force` is high exactly while SAMPLE-Z is active. SAMPLE leaves it low.
- R7: Under IDCODE, Capture-DR loads the parameter `ID_CODE`, which shifts out LSB first. TDI enters the most significant stage, so bit 32 onward of the output is the TDI stream.
- R8: Under bypass, Capture-DR loads 0, and the output is TDI delayed by one shift. The bypass stage holds its value once Shift-DR is left.
- R9: Under SAMPLE and SAMPLE-Z, Capture-DR copies `pin_sample` (bit 0 nearest TDO). The register is `BSR_LEN` stages long, so the TDI stream appears after `BSR_LEN` bits.
- R10: `tdo` and `tdo_oe` change only on the falling test clock. `tdo_oe` is high only in Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, read as 1 unless driven 0 |
| tdi | input | 1 | Serial data in, read as 1 unless driven 0 |
| pin_sample | input | BSR_LEN | Parallel device pin values for the boundary register |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Pad enable for tdo |
| hiz_force | output | 1 | Forces the memory data pins to high impedance |

## Verification
The bench builds the block with `BSR_LEN` = 6 and an `ID_CODE` of 32'h1A5C_3E07. The short boundary chain lets one scan of eight bits show both the captured pins and the point where TDI emerges. The asymmetric identification value exposes any bit reversal or misplaced capture. Overscanning the 32-bit code by two bits also makes the entry point of TDI visible.

// File: rtl/memtap_pkg.sv
package memtap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} path_e;

  localparam logic [IR_W-1:0] OP_IDCODE   = 3'b001;
  localparam logic [IR_W-1:0] IR_CAPT_PAT = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      S_RESET:  tap_next = m ? S_RESET  : S_IDLE;
      S_IDLE:   tap_next = m ? S_SEL_DR : S_IDLE;
      S_SEL_DR: tap_next = m ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: tap_next = m ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  tap_next = m ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: tap_next = m ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: tap_next = m ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: tap_next = m ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: tap_next = m ? S_SEL_DR : S_IDLE;
      S_SEL_IR: tap_next = m ? S_RESET  : S_CAP_IR;
      S_CAP_IR: tap_next = m ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  tap_next = m ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: tap_next = m ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: tap_next = m ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: tap_next = m ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: tap_next = m ? S_SEL_DR : S_IDLE;
      default:  tap_next = S_RESET;
    endcase
  endfunction

  function automatic path_e op_path(input logic [IR_W-1:0] op);
    case (op)
      3'b001:                 op_path = PATH_ID;
      3'b000, 3'b010, 3'b100: op_path = PATH_BSR;
      default:                op_path = PATH_BYP;
    endcase
  endfunction

  function automatic logic op_hiz(input logic [IR_W-1:0] op);
    op_hiz = (op == 3'b000) || (op == 3'b010);
  endfunction

endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
  import memtap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state,
  output logic       ev_reset,
  output logic       ev_cap_dr,
  output logic       ev_sh_dr,
  output logic       ev_cap_ir,
  output logic       ev_sh_ir,
  output logic       ev_upd_ir
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= S_RESET;
    else        state <= tap_next(state, tms);
  end

  assign ev_reset  = (state == S_RESET);
  assign ev_cap_dr = (state == S_CAP_DR);
  assign ev_sh_dr  = (state == S_SH_DR);
  assign ev_cap_ir = (state == S_CAP_IR);
  assign ev_sh_ir  = (state == S_SH_IR);
  assign ev_upd_ir = (state == S_UPD_IR);

endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
  import memtap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  logic            ev_reset,
  input  logic            ev_cap_ir,
  input  logic            ev_sh_ir,
  input  logic            ev_upd_ir,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr <= IR_CAPT_PAT;
      ir_q  <= OP_IDCODE;
    end else begin
      if (ev_cap_ir)     ir_sr <= IR_CAPT_PAT;
      else if (ev_sh_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (ev_reset)       ir_q <= OP_IDCODE;
      else if (ev_upd_ir) ir_q <= ir_sr;
    end
  end

  assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/memtap_dr.sv
module memtap_dr
  import memtap_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter int          ID_W    = 32,
  parameter logic [31:0] ID_CODE = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tdi,
  input  path_e              path,
  input  logic               ev_cap_dr,
  input  logic               ev_sh_dr,
  input  logic [BSR_LEN-1:0] pins,
  output logic               dr_lsb,
  output logic               byp_q
);

  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr;

  wire sel_byp = (path == PATH_BYP);
  wire sel_id  = (path == PATH_ID);
  wire sel_bsr = (path == PATH_BSR);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q <= 1'b0;
      id_sr <= '0;
    end else begin
      if (sel_byp && ev_cap_dr)     byp_q <= 1'b0;
      else if (sel_byp && ev_sh_dr) byp_q <= tdi;
      if (sel_id && ev_cap_dr)      id_sr <= ID_CODE[ID_W-1:0];
      else if (sel_id && ev_sh_dr)  id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  generate
    if (BSR_LEN == 1) begin : g_bsr_one
      always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)                   bsr_sr <= '0;
        else if (sel_bsr && ev_cap_dr) bsr_sr <= pins;
        else if (sel_bsr && ev_sh_dr)  bsr_sr <= tdi;
      end
    end else begin : g_bsr_chain
      always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)                   bsr_sr <= '0;
        else if (sel_bsr && ev_cap_dr) bsr_sr <= pins;
        else if (sel_bsr && ev_sh_dr)  bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
      end
    end
  endgenerate

  always_comb begin
    case (path)
      PATH_ID:  dr_lsb = id_sr[0];
      PATH_BSR: dr_lsb = bsr_sr[0];
      default:  dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/memtap.sv
module memtap
  import memtap_pkg::*;
#(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] ID_CODE = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_sample,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               hiz_force
);

  localparam int ID_W = 32;

  // an input not driven low reads as 1 (weak pull-up model)
  logic tms_eff, tdi_eff;
  assign tms_eff = (tms !== 1'b0);
  assign tdi_eff = (tdi !== 1'b0);

  tap_state_e      state;
  logic            ev_reset, ev_cap_dr, ev_sh_dr, ev_cap_ir, ev_sh_ir, ev_upd_ir;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, dr_lsb, byp_q;
  path_e           path;

  memtap_fsm u_fsm (
    .tck(tck), .por_n(por_n), .tms(tms_eff), .state(state),
    .ev_reset(ev_reset), .ev_cap_dr(ev_cap_dr), .ev_sh_dr(ev_sh_dr),
    .ev_cap_ir(ev_cap_ir), .ev_sh_ir(ev_sh_ir), .ev_upd_ir(ev_upd_ir)
  );

  memtap_ir u_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi_eff), .ev_reset(ev_reset),
    .ev_cap_ir(ev_cap_ir), .ev_sh_ir(ev_sh_ir), .ev_upd_ir(ev_upd_ir),
    .ir_q(ir_q), .ir_lsb(ir_lsb)
  );

  assign path      = op_path(ir_q);
  assign hiz_force = op_hiz(ir_q);

  memtap_dr #(.BSR_LEN(BSR_LEN), .ID_W(ID_W), .ID_CODE(ID_CODE)) u_dr (
    .tck(tck), .por_n(por_n), .tdi(tdi_eff), .path(path),
    .ev_cap_dr(ev_cap_dr), .ev_sh_dr(ev_sh_dr), .pins(pin_sample),
    .dr_lsb(dr_lsb), .byp_q(byp_q)
  );

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= ev_sh_ir ? ir_lsb : dr_lsb;
      tdo_oe <= ev_sh_ir || ev_sh_dr;
    end
  end

endmodule

// File: rtl/memtap_chk.sv
module memtap_chk
  import memtap_pkg::*;
(
  input logic            tck,
  input logic            por_n,
  input logic            tms_eff,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic            hiz_force,
  input path_e           path,
  input logic            byp_q,
  input logic            tdo_oe
);

  a_r1_reset_holds: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_RESET && tms_eff) |=> state == S_RESET);

  a_r1_shift_dr_exit: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_SH_DR && tms_eff) |=> state == S_EX1_DR);

  a_r2_reset_idcode: assert property (@(posedge tck) disable iff (!por_n)
    state == S_RESET |=> (ir_q == 3'b001 && !hiz_force));

  a_r4_ir_only_on_update: assert property (@(posedge tck) disable iff (!por_n)
    (state != S_UPD_IR && state != S_RESET) |=> $stable(ir_q));

  a_r6_hiz_rises_after_update: assert property (@(posedge tck) disable iff (!por_n)
    $rose(hiz_force) |-> $past(state) == S_UPD_IR);

  a_r8_bypass_captures_zero: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_CAP_DR && path == PATH_BYP) |=> !byp_q);

  a_r8_bypass_holds: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_EX1_DR || state == S_PAU_DR || state == S_EX2_DR || state == S_UPD_DR)
      |=> $stable(byp_q));

  a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (state == S_SH_DR || state == S_SH_IR));

endmodule

bind memtap memtap_chk u_chk (
  .tck(tck), .por_n(por_n), .tms_eff(tms_eff), .state(state), .ir_q(ir_q),
  .hiz_force(hiz_force), .path(path), .byp_q(byp_q), .tdo_oe(tdo_oe)
);

// File: tb/memtap_tb.sv
module memtap_tb;

  localparam int          BSR_LEN = 6;
  localparam logic [31:0] ID_CODE = 32'h1A5C_3E07;

  logic tck = 1'b0;
  logic por_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b1;
  logic [BSR_LEN-1:0] pins = '0;
  logic tdo, tdo_oe, hiz_force;

  int checks = 0;
  int errors = 0;

  always #2 tck = ~tck;  // 250 MHz

  memtap #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) u_dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_sample(pins),
    .tdo(tdo), .tdo_oe(tdo_oe), .hiz_force(hiz_force)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    check(!tdo_oe, "R10 oe off after shift-dr", {63'd0, tdo_oe}, 64'd0);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    logic hiz_before;
    hiz_before = hiz_force;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, op[i]);
    end
    tick(1, 0);
    check(hiz_force == hiz_before, "R4 no effect before update-ir",
          {63'd0, hiz_force}, {63'd0, hiz_before});
    tick(0, 0);
  endtask

  task automatic t_reset;
    logic [63:0] o;
    check(!hiz_force, "R2 hiz low after power-on", {63'd0, hiz_force}, 64'd0);
    check(!tdo_oe, "R10 oe low after power-on", {63'd0, tdo_oe}, 64'd0);
    tick(0, 0);
    scan_dr(32, 64'd0, o);
    check(o[31:0] == ID_CODE, "R1 R2 idcode after power-on", o, {32'd0, ID_CODE});
  endtask

  task automatic t_ir_capture;
    logic [2:0] c;
    load_ir(3'b011, c);
    check(c == 3'b001, "R3 capture-ir pattern", {61'd0, c}, 64'd1);
  endtask

  task automatic t_bypass;
    logic [2:0] c;
    logic [63:0] o;
    logic [2:0] ops [4] = '{3'b011, 3'b101, 3'b110, 3'b111};
    for (int k = 0; k < 4; k++) begin
      load_ir(ops[k], c);
      check(!hiz_force, "R6 bypass no hiz", {63'd0, hiz_force}, 64'd0);
      scan_dr(8, 64'hB5, o);
      check(o[7:0] == 8'h6A, "R5 R8 bypass one-bit delay", o, 64'h6A);
    end
  endtask

  task automatic t_sample(input logic [2:0] op, input logic exp_hiz,
                          input logic [BSR_LEN-1:0] p);
    logic [2:0] c;
    logic [63:0] o;
    logic [63:0] e;
    load_ir(op, c);
    check(hiz_force == exp_hiz, "R6 hiz per instruction", {63'd0, hiz_force},
          {63'd0, exp_hiz});
    pins = p;
    scan_dr(BSR_LEN + 2, 64'h2, o);
    e = {56'd0, 2'b10, p};
    check(o[BSR_LEN+1:0] == e[BSR_LEN+1:0], "R5 R9 boundary capture and length", o, e);
  endtask

  task automatic t_idcode;
    logic [2:0] c;
    logic [63:0] o;
    load_ir(3'b001, c);
    check(!hiz_force, "R6 idcode no hiz", {63'd0, hiz_force}, 64'd0);
    scan_dr(34, 64'h1, o);
    check(o[33:0] == {2'b01, ID_CODE}, "R5 R7 idcode then tdi", o, {30'd0, 2'b01, ID_CODE});
  endtask

  task automatic t_tdo_edge;
    logic [2:0] c;
    load_ir(3'b111, c);
    tick(1, 0); tick(0, 0); tick(0, 0);
    check(tdo == 1'b0 && tdo_oe, "R10 captured bypass on tdo", {62'd0, tdo_oe, tdo}, 64'd2);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    check(tdo == 1'b0, "R10 tdo steady at rising edge", {63'd0, tdo}, 64'd0);
    @(negedge tck); #1;
    check(tdo == 1'b1, "R10 tdo updates at falling edge", {63'd0, tdo}, 64'd1);
    tick(1, 0); tick(1, 0); tick(0, 0);
  endtask

  task automatic t_tlr;
    logic [2:0] c;
    logic [63:0] o;
    load_ir(3'b010, c);
    check(hiz_force, "R6 sample-z hiz set", {63'd0, hiz_force}, 64'd1);
    tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(1, 0);
    check(!hiz_force, "R1 R2 five tms-high clocks reset", {63'd0, hiz_force}, 64'd0);
    tick(0, 0);
    scan_dr(32, 64'd0, o);
    check(o[31:0] == ID_CODE, "R2 idcode after tms reset", o, {32'd0, ID_CODE});
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #9;
    por_n = 1'b1;
    @(negedge tck); #1;
    t_reset();
    t_ir_capture();
    t_bypass();
    t_sample(3'b000, 1'b1, 6'b101101);
    t_sample(3'b010, 1'b1, 6'b010011);
    t_sample(3'b100, 1'b0, 6'b110001);
    t_idcode();
    t_tdo_edge();
    t_tlr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule